// File: doc/BRIEF.md
# Shared Debug Port Arbiter

Several on-chip debug sources share one off-chip auxiliary output port. This block decides which source may use the port. Each source raises a request when it has something to send. The arbiter answers with a one-cycle grant. The granted source then holds the port for as long as it keeps its busy line high. While a source owns the port, the arbiter steers that source's data bus onto the port and raises the port's output clock enable. When no source owns the port, the port shows all zeros.

A global port-enable input gates arbitration. While it is low, no grant is issued. Fixed priority applies: source 0 wins over every other source, and priority falls as the index rises. A requester is also held off while any source with a lower index still reports busy. If a granted source never asserts busy, its claim lapses and arbitration resumes.

Top module: `dbg_port_arb`

## Requirements
- R1: In the idle state, the lowest-indexed requesting source wins. Its grant bit (grant_o[i] for source i) is high in the cycle after the clock edge that sampled the request.
- R2: If any source with an index below the winner has busy_i high in the sampling cycle, no grant is issued in the following cycle. Busy lines of sources with a higher index than the winner have no effect.
- R3: While port_en_i is low, grant_o stays zero for every request pattern. The first grant appears one cycle after port_en_i is sampled high.
- R4: At most one bit of grant_o is set in any cycle. Each grant lasts exactly one cycle, even if the request is held.
- R5: From the cycle after its grant, for as long as its busy_i bit is high, the owning source's DW-bit data slice (bits i*DW+DW-1 down to i*DW) appears on port_data_o. In that window sel_o equals the owner's index and port_clk_en_o is 1.
- R6: While an owner stays busy, no grant is issued, even to a higher-priority source that is requesting.
- R7: If the granted source has busy low in the cycle after its grant, the port stays zero in that cycle and ownership is released. A held request is granted again three cycles after the first grant.
- R8: When no source is driving, port_data_o is all zeros, sel_o is 0 and port_clk_en_o is 0, whatever the source data buses carry. This includes the reset state.
- R9: After the owner drops busy, the port goes to zero in the next cycle. A pending request is granted one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | 1 | Gates all arbitration |
| req_i | input | N_SRC | Request from each source |
| busy_i | input | N_SRC | Busy from each source |
| src_data_i | input | N_SRC*DW | Concatenated source data buses, source i in bits i*DW+DW-1 down to i*DW |
| grant_o | output | N_SRC | One-cycle grant to each source |
| sel_o | output | $clog2(N_SRC) | Output multiplexer select, owner index |
| port_data_o | output | DW | Auxiliary port data |
| port_clk_en_o | output | 1 | Port output clock enable, high while an owner drives |

## Verification
The idle arbiter is swept over every combination of four request bits and four busy bits. This separates a correct priority choice from a case where a higher-priority busy should block the grant, and from a case where a lower-priority busy should be ignored. The same request patterns are repeated with the port disabled. Three timed sequences follow. One lets an owner hold the port while a higher-priority request waits. One has the granted source never assert busy. One has a held request, to show that the grant is a single pulse and to check when the next grant arrives. These sequences pin down the exact cycles of release and regrant, and show whether data is forwarded only while the owner is busy.

// File: rtl/dbg_arb_pkg.sv
package dbg_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GNT  = 2'd1,
    ST_OWN  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/dbg_arb_pick.sv
module dbg_arb_pick #(
  parameter int N_SRC = 4,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] busy_i,
  output logic             win_valid_o,
  output logic [IW-1:0]    win_idx_o
);
  logic found;
  logic hi_busy;

  // first requester wins; blocked if any lower index is busy
  always_comb begin
    found       = 1'b0;
    hi_busy     = 1'b0;
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (!found && req_i[i]) begin
        found       = 1'b1;
        win_idx_o   = IW'(i);
        win_valid_o = !hi_busy;
      end
      hi_busy = hi_busy | busy_i[i];
    end
  end
endmodule

// File: rtl/dbg_arb_fsm.sv
module dbg_arb_fsm
  import dbg_arb_pkg::*;
#(
  parameter int N_SRC = 4,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             port_en_i,
  input  logic             win_valid_i,
  input  logic [IW-1:0]    win_idx_i,
  input  logic [N_SRC-1:0] busy_i,
  output logic [N_SRC-1:0] grant_o,
  output logic [IW-1:0]    owner_o,
  output logic             drive_o
);
  arb_state_e      state_q, state_d;
  logic [IW-1:0]   owner_q;
  logic [N_SRC-1:0] grant_q;
  logic            start;
  logic            owner_busy;

  assign owner_busy = busy_i[owner_q];
  assign start      = (state_q == ST_IDLE) && port_en_i && win_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_GNT;
      ST_GNT:  state_d = ST_OWN;
      ST_OWN:  if (!owner_busy) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      owner_q <= '0;
      grant_q <= '0;
    end else begin
      state_q <= state_d;
      grant_q <= start ? (N_SRC'(1) << win_idx_i) : '0;
      if (start) owner_q <= win_idx_i;
    end
  end

  assign grant_o = grant_q;
  assign owner_o = owner_q;
  assign drive_o = (state_q == ST_OWN) && owner_busy;
endmodule

// File: rtl/dbg_arb_mux.sv
module dbg_arb_mux #(
  parameter int N_SRC = 4,
  parameter int DW    = 8,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC*DW-1:0] src_data_i,
  input  logic [IW-1:0]       sel_i,
  input  logic                drive_i,
  output logic [DW-1:0]       data_o
);
  logic [DW-1:0] slice [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : g_slice
    assign slice[g] = src_data_i[g*DW +: DW];
  end

  assign data_o = drive_i ? slice[sel_i] : '0;
endmodule

// File: rtl/dbg_port_arb.sv
module dbg_port_arb #(
  parameter int N_SRC = 4,
  parameter int DW    = 8,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                port_en_i,
  input  logic [N_SRC-1:0]    req_i,
  input  logic [N_SRC-1:0]    busy_i,
  input  logic [N_SRC*DW-1:0] src_data_i,
  output logic [N_SRC-1:0]    grant_o,
  output logic [IW-1:0]       sel_o,
  output logic [DW-1:0]       port_data_o,
  output logic                port_clk_en_o
);
  logic          win_valid;
  logic [IW-1:0] win_idx;
  logic [IW-1:0] owner;
  logic          drive;

  dbg_arb_pick #(.N_SRC(N_SRC)) pick_i (
    .req_i       (req_i),
    .busy_i      (busy_i),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx)
  );

  dbg_arb_fsm #(.N_SRC(N_SRC)) fsm_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .port_en_i   (port_en_i),
    .win_valid_i (win_valid),
    .win_idx_i   (win_idx),
    .busy_i      (busy_i),
    .grant_o     (grant_o),
    .owner_o     (owner),
    .drive_o     (drive)
  );

  assign sel_o         = drive ? owner : '0;
  assign port_clk_en_o = drive;

  dbg_arb_mux #(.N_SRC(N_SRC), .DW(DW)) mux_i (
    .src_data_i (src_data_i),
    .sel_i      (sel_o),
    .drive_i    (drive),
    .data_o     (port_data_o)
  );
endmodule

// File: rtl/dbg_port_arb_chk.sv
module dbg_port_arb_chk #(
  parameter int N_SRC = 4,
  parameter int DW    = 8,
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                port_en_i,
  input logic [N_SRC-1:0]    req_i,
  input logic [N_SRC-1:0]    busy_i,
  input logic [N_SRC*DW-1:0] src_data_i,
  input logic [N_SRC-1:0]    grant_o,
  input logic [IW-1:0]       sel_o,
  input logic [DW-1:0]       port_data_o,
  input logic                port_clk_en_o
);
  // R4
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  // R4
  grant_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0) |=> (grant_o == '0));

  // R3
  port_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |=> (grant_o == '0));

  // R6
  owner_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_clk_en_o |=> (grant_o == '0));

  // R5
  owner_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_clk_en_o |-> busy_i[sel_o]);

  // R8
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_clk_en_o |-> (port_data_o == '0 && sel_o == '0));

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    // R1 R2
    prio_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o[g] |-> ($past(req_i[g]) &&
                      (($past(req_i) | $past(busy_i)) &
                       ((N_SRC'(1) << g) - N_SRC'(1))) == '0));
  end
endmodule

bind dbg_port_arb dbg_port_arb_chk #(.N_SRC(N_SRC), .DW(DW)) chk_i (.*);

// File: tb/dbg_port_arb_tb.sv
module dbg_port_arb_tb_top;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int IW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            port_en = 1'b0;
  logic [N-1:0]    req = '0;
  logic [N-1:0]    busy = '0;
  logic [N*DW-1:0] src_data;
  logic [N-1:0]    grant;
  logic [IW-1:0]   sel;
  logic [DW-1:0]   pdata;
  logic            clk_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dbg_port_arb #(.N_SRC(N), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(port_en), .req_i(req),
    .busy_i(busy), .src_data_i(src_data), .grant_o(grant), .sel_o(sel),
    .port_data_o(pdata), .port_clk_en_o(clk_en)
  );

  function automatic logic [DW-1:0] dval(int i);
    return DW'(8'h3C + 8'h11 * i);
  endfunction

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic idle_chk(string rq);
    chk(rq, int'(pdata), 0);
    chk(rq, int'(sel), 0);
    chk(rq, int'(clk_en), 0);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) src_data[i*DW +: DW] = dval(i);
    step();
    // R8 reset state
    chk("R8 reset grant", int'(grant), 0);
    idle_chk("R8 reset");
    step();
    rst_n = 1'b1;
    step();

    // R3 disabled: no grants
    for (int r = 1; r < 16; r++) begin
      req = N'(r);
      step();
      chk("R3 disabled", int'(grant), 0);
      step();
      chk("R3 disabled", int'(grant), 0);
    end
    req = 4'b1000;
    port_en = 1'b1;
    step();
    chk("R3 enable", int'(grant), 32'h8);
    req = '0;
    step(); step();

    // R1 R2 R8 exhaustive idle sweep
    for (int r = 0; r < 16; r++) begin
      for (int b = 0; b < 16; b++) begin
        int w;
        int exp;
        w = -1;
        for (int i = 0; i < N; i++) if (((r >> i) & 1) != 0 && w < 0) w = i;
        exp = 0;
        if (w >= 0 && (b & ((1 << w) - 1)) == 0) exp = 1 << w;
        req  = N'(r);
        busy = N'(b);
        step();
        if ((b & ((1 << (w < 0 ? 0 : w)) - 1)) != 0)
          chk("R2 blocked", int'(grant), exp);
        else
          chk("R1 priority", int'(grant), exp);
        idle_chk("R8 no owner");
        req = '0;
        busy = '0;
        step(); step();
        chk("R8 after release", int'(pdata), 0);
      end
    end

    // R5 R6 R9 ownership
    req = 4'b0100;
    step();
    chk("R1 grant src2", int'(grant), 32'h4);
    chk("R5 no data in grant cycle", int'(clk_en), 0);
    busy = 4'b0100;
    req  = '0;
    step();
    chk("R5 data", int'(pdata), int'(dval(2)));
    chk("R5 sel", int'(sel), 2);
    chk("R5 clk_en", int'(clk_en), 1);
    req = 4'b0001;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R6 no preempt", int'(grant), 0);
      chk("R6 data held", int'(pdata), int'(dval(2)));
    end
    busy = '0;
    step();
    chk("R9 release grant", int'(grant), 0);
    idle_chk("R9 released");
    step();
    chk("R9 regrant", int'(grant), 32'h1);
    req = '0;
    step(); step();

    // R7 R4 failed busy, held request
    req = 4'b0010;
    step();
    chk("R4 first grant", int'(grant), 32'h2);
    step();
    chk("R4 pulse", int'(grant), 0);
    idle_chk("R7 no busy");
    step();
    chk("R7 idle", int'(grant), 0);
    step();
    chk("R7 regrant", int'(grant), 32'h2);
    req = '0;
    step(); step();
    idle_chk("R8 end");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule